// File: doc/BRIEF.md
# Free-Running Interval Timer

This block is a 16-bit down-counter paired with a 16-bit reload latch, running continuously. On every timeout it raises a timer interrupt flag, inverts a square-wave output and reloads itself from the latch with no help from the host. The spacing of timeouts therefore depends only on the latch contents and the clock-enable rate, never on how quickly software services the interrupt.

The host reaches the timer through a byte-wide register bus. Writing either latch byte only shapes the period that follows the current one. Writing the upper counter byte retriggers the countdown at once, so software that keeps rewriting it can postpone a timeout indefinitely. Because the square wave flips on each timeout, software can load a new latch value in every half-cycle and build arbitrary waveforms. An enable mask gates an active-low interrupt line. A control bit chooses whether the output pin carries the square wave or an ordinary port data bit.

Top module: `frt_top`

## Requirements
- R1: After synchronous reset the counter, both latch bytes, the control byte, the enable byte, the timer flag and the square-wave state are all zero, and `irq_n` is 1. The counter holds its value and produces no timeout until the first write to the upper counter byte arms it.
- R2: Once armed, the counter decreases by one on each cycle with `tick` high while it is non-zero and no reload is pending. It does not change on cycles with `tick` low. A read at address 0 returns the low counter byte.
- R3: A `tick` that finds the armed counter at zero is a timeout. It sets the timer flag and inverts the square wave. The next `tick` copies the full latch into the counter, so timeouts repeat every latch value plus 2 ticks.
- R4: Writes at address 0 or 2 load the low latch byte and a write at address 3 loads the high latch byte. None of these changes the running count, and the new latch value takes effect at the next reload. Reads at addresses 2 and 3 return the latch bytes.
- R5: A write at address 1 loads the high latch byte with the data and loads the counter with {data, low latch byte}. It cancels any pending reload, clears the timer flag and arms the counter. It takes precedence over a `tick` in the same cycle.
- R6: The timer flag clears on a read at address 0, on a write at address 3, or on a write at address 5 with bit 6 set. A timeout in the same cycle wins over the clear.
- R7: A read at address 5 returns the timer flag in bit 6 and, in bit 7, the flag ANDed with enable bit 6; all other bits read 0. Writing 0 to bit 6 at address 5 leaves the flag unchanged.
- R8: `irq_n` is 0 exactly when the timer flag and bit 6 of the enable byte are both 1.
- R9: When control bit 0 (address 4) is 1, `wave_pin` carries the square-wave state; when it is 0, `wave_pin` follows `port_in`.
- R10: A read at address 1 returns the upper counter byte and does not affect the timer flag.
- R11: Address 4 reads back the control byte, address 6 reads back the enable byte, and address 7 reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Count enable; one decrement step per high cycle |
| bus_addr | input | 3 | Register address |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access (for side effects) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the addressed register, combinational |
| port_in | input | 1 | Ordinary port data routed to the pin when the wave is off |
| wave_pin | output | 1 | Square wave or port data |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
The assertions assume that `bus_wr` and `bus_rd` are never high together and that each access lasts one cycle. They also assume that `tick` is a plain level sampled on the clock, with no tie to bus activity. The stimulus issues at most one access per cycle and places accesses on cycles with and without `tick`, including cycles where a timeout coincides with a flag clear or a retrigger. The tick rate varies between every cycle and every third cycle, so the rule of holding without a tick and the latch-plus-2 spacing are both exercised.

// File: rtl/frt_pkg.sv
package frt_pkg;

    parameter int DATA_W = 8;
    parameter int CNT_W  = 2 * DATA_W;
    parameter int ADDR_W = 3;

    localparam int TMR_FLAG_BIT = 6;
    localparam int ANY_FLAG_BIT = 7;
    localparam int WAVE_EN_BIT  = 0;

    typedef enum logic [ADDR_W-1:0] {
        REG_CNT_LO = 3'd0,
        REG_CNT_HI = 3'd1,
        REG_LAT_LO = 3'd2,
        REG_LAT_HI = 3'd3,
        REG_CTRL   = 3'd4,
        REG_FLAGS  = 3'd5,
        REG_IEN    = 3'd6,
        REG_NONE   = 3'd7
    } reg_sel_e;

    typedef struct packed {
        logic rd_cnt_lo;
        logic wr_lat_lo;
        logic wr_cnt_hi;
        logic wr_lat_hi;
        logic wr_ctrl;
        logic wr_flags;
        logic wr_ien;
    } access_t;

    function automatic access_t decode_access(input logic wr, input logic rd,
                                              input logic [ADDR_W-1:0] addr);
        access_t a;
        reg_sel_e sel;
        sel         = reg_sel_e'(addr);
        a           = '0;
        a.rd_cnt_lo = rd && (sel == REG_CNT_LO);
        a.wr_lat_lo = wr && ((sel == REG_CNT_LO) || (sel == REG_LAT_LO));
        a.wr_cnt_hi = wr && (sel == REG_CNT_HI);
        a.wr_lat_hi = wr && (sel == REG_LAT_HI);
        a.wr_ctrl   = wr && (sel == REG_CTRL);
        a.wr_flags  = wr && (sel == REG_FLAGS);
        a.wr_ien    = wr && (sel == REG_IEN);
        return a;
    endfunction

endpackage

// File: rtl/frt_regs.sv
module frt_regs
    import frt_pkg::*;
#(
    parameter int DW = frt_pkg::DATA_W,
    parameter int CW = 2 * DW
) (
    input  logic          clk,
    input  logic          rst,
    input  access_t       acc,
    input  logic [DW-1:0] wdata,
    output logic [CW-1:0] latch,
    output logic [DW-1:0] ctrl,
    output logic [DW-1:0] ien
);

    logic [DW-1:0] lat_lo_q, lat_hi_q, ctrl_q, ien_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            lat_lo_q <= '0;
            lat_hi_q <= '0;
            ctrl_q   <= '0;
            ien_q    <= '0;
        end else begin
            if (acc.wr_lat_lo)                  lat_lo_q <= wdata;
            if (acc.wr_lat_hi || acc.wr_cnt_hi) lat_hi_q <= wdata;
            if (acc.wr_ctrl)                    ctrl_q   <= wdata;
            if (acc.wr_ien)                     ien_q    <= wdata;
        end
    end

    assign latch = {lat_hi_q, lat_lo_q};
    assign ctrl  = ctrl_q;
    assign ien   = ien_q;

endmodule

// File: rtl/frt_counter.sv
module frt_counter #(
    parameter int CW = frt_pkg::CNT_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    input  logic [CW-1:0] latch,
    output logic [CW-1:0] cnt,
    output logic          timeout,
    output logic          reload_pend,
    output logic          armed
);

    logic [CW-1:0] cnt_q;
    logic          pend_q, armed_q;
    logic          step;

    assign step    = tick && armed_q && !load;
    assign timeout = step && !pend_q && (cnt_q == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q   <= '0;
            pend_q  <= 1'b0;
            armed_q <= 1'b0;
        end else if (load) begin
            cnt_q   <= load_val;
            pend_q  <= 1'b0;
            armed_q <= 1'b1;
        end else if (step) begin
            if (pend_q) begin
                cnt_q  <= latch;
                pend_q <= 1'b0;
            end else if (cnt_q == '0) begin
                pend_q <= 1'b1;
            end else begin
                cnt_q <= cnt_q - CW'(1);
            end
        end
    end

    assign cnt         = cnt_q;
    assign reload_pend = pend_q;
    assign armed       = armed_q;

endmodule

// File: rtl/frt_flags.sv
module frt_flags
    import frt_pkg::*;
#(
    parameter int DW = frt_pkg::DATA_W
) (
    input  logic          clk,
    input  logic          rst,
    input  access_t       acc,
    input  logic [DW-1:0] wdata,
    input  logic          timeout,
    input  logic          tmr_ien,
    output logic          flag,
    output logic          wave,
    output logic          irq_n
);

    logic flag_q, wave_q, clr;

    assign clr = acc.rd_cnt_lo || acc.wr_lat_hi || acc.wr_cnt_hi ||
                 (acc.wr_flags && wdata[TMR_FLAG_BIT]);

    always_ff @(posedge clk) begin
        if (rst) begin
            flag_q <= 1'b0;
            wave_q <= 1'b0;
        end else begin
            if (timeout)  flag_q <= 1'b1;
            else if (clr) flag_q <= 1'b0;
            if (timeout)  wave_q <= ~wave_q;
        end
    end

    assign flag  = flag_q;
    assign wave  = wave_q;
    assign irq_n = ~(flag_q && tmr_ien);

endmodule

// File: rtl/frt_top.sv
module frt_top
    import frt_pkg::*;
#(
    parameter int DW = frt_pkg::DATA_W,
    parameter int AW = frt_pkg::ADDR_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick,
    input  logic [AW-1:0] bus_addr,
    input  logic          bus_wr,
    input  logic          bus_rd,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    input  logic          port_in,
    output logic          wave_pin,
    output logic          irq_n
);

    localparam int CW = 2 * DW;

    access_t       acc;
    logic [CW-1:0] latch, cnt, load_val;
    logic [DW-1:0] ctrl, ien, flags_rd;
    logic          timeout, reload_pend, armed, flag, wave, retrig, tmr_ien;

    assign acc      = decode_access(bus_wr, bus_rd, bus_addr);
    assign retrig   = acc.wr_cnt_hi;
    assign load_val = {bus_wdata, latch[DW-1:0]};
    assign tmr_ien  = ien[TMR_FLAG_BIT];

    frt_regs #(.DW(DW), .CW(CW)) i_regs (
        .clk(clk), .rst(rst), .acc(acc), .wdata(bus_wdata),
        .latch(latch), .ctrl(ctrl), .ien(ien)
    );

    frt_counter #(.CW(CW)) i_counter (
        .clk(clk), .rst(rst), .tick(tick), .load(retrig), .load_val(load_val),
        .latch(latch), .cnt(cnt), .timeout(timeout),
        .reload_pend(reload_pend), .armed(armed)
    );

    frt_flags #(.DW(DW)) i_flags (
        .clk(clk), .rst(rst), .acc(acc), .wdata(bus_wdata), .timeout(timeout),
        .tmr_ien(tmr_ien), .flag(flag), .wave(wave), .irq_n(irq_n)
    );

    always_comb begin
        flags_rd               = '0;
        flags_rd[TMR_FLAG_BIT] = flag;
        flags_rd[ANY_FLAG_BIT] = flag && tmr_ien;
    end

    always_comb begin
        case (reg_sel_e'(bus_addr))
            REG_CNT_LO: bus_rdata = cnt[DW-1:0];
            REG_CNT_HI: bus_rdata = cnt[CW-1:DW];
            REG_LAT_LO: bus_rdata = latch[DW-1:0];
            REG_LAT_HI: bus_rdata = latch[CW-1:DW];
            REG_CTRL:   bus_rdata = ctrl;
            REG_FLAGS:  bus_rdata = flags_rd;
            REG_IEN:    bus_rdata = ien;
            default:    bus_rdata = '0;
        endcase
    end

    assign wave_pin = ctrl[WAVE_EN_BIT] ? wave : port_in;

endmodule

// File: rtl/frt_checker.sv
module frt_checker #(
    parameter int DW = 8,
    parameter int CW = 16
) (
    input logic          clk,
    input logic          rst,
    input logic          tick,
    input logic          retrig,
    input logic [DW-1:0] bus_wdata,
    input logic [CW-1:0] cnt,
    input logic [CW-1:0] latch,
    input logic          reload_pend,
    input logic          armed,
    input logic          flag,
    input logic          wave,
    input logic          irq_n
);

    AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (rst)
        (!tick && !retrig) |=> $stable(cnt)); // R2

    AST_DECREMENT: assert property (@(posedge clk) disable iff (rst)
        (tick && armed && !retrig && !reload_pend && cnt != '0)
        |=> cnt == $past(cnt) - CW'(1)); // R2

    AST_TIMEOUT_EFFECT: assert property (@(posedge clk) disable iff (rst)
        (tick && armed && !retrig && !reload_pend && cnt == '0)
        |=> (flag && wave != $past(wave))); // R3

    AST_RELOAD: assert property (@(posedge clk) disable iff (rst)
        (tick && armed && !retrig && reload_pend) |=> cnt == $past(latch)); // R3

    AST_WAVE_ONLY_TIMEOUT: assert property (@(posedge clk) disable iff (rst)
        !(tick && armed && !retrig && !reload_pend && cnt == '0) |=> $stable(wave)); // R3

    AST_RETRIGGER: assert property (@(posedge clk) disable iff (rst)
        retrig |=> (cnt[CW-1:DW] == $past(bus_wdata) && !flag && armed)); // R5

    AST_UNARMED_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!armed && !retrig) |=> (cnt == '0 && !flag)); // R1

    AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (rst)
        !irq_n |-> flag); // R8

endmodule

bind frt_top frt_checker #(.DW(DW), .CW(2 * DW)) i_chk (
    .clk(clk), .rst(rst), .tick(tick), .retrig(retrig), .bus_wdata(bus_wdata),
    .cnt(cnt), .latch(latch), .reload_pend(reload_pend), .armed(armed),
    .flag(flag), .wave(wave), .irq_n(irq_n)
);

// File: tb/test_frt_top.sv
`timescale 1ns/1ps
module test_frt_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick = 1'b0;
    logic [2:0] bus_addr = '0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       port_in = 1'b0;
    logic       wave_pin;
    logic       irq_n;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    // behavioural reference state
    int m_cnt, m_lat, m_ctrl, m_ien;
    bit m_pend, m_armed, m_flag, m_wave;
    int toggles;

    always #10 clk = ~clk;

    frt_top i_frt_top (
        .clk(clk), .rst(rst), .tick(tick), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .port_in(port_in), .wave_pin(wave_pin), .irq_n(irq_n)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic int exp_read(input int a);
        case (a)
            0: return m_cnt & 8'hFF;
            1: return (m_cnt >> 8) & 8'hFF;
            2: return m_lat & 8'hFF;
            3: return (m_lat >> 8) & 8'hFF;
            4: return m_ctrl;
            5: return (m_flag ? 8'h40 : 0) | ((m_flag && m_ien[6]) ? 8'h80 : 0);
            6: return m_ien;
            default: return 0;
        endcase
    endfunction

    function automatic string tag_of(input int a);
        case (a)
            0: return "R2";
            1: return "R10";
            2, 3: return "R4";
            4: return "R9";
            5: return "R7";
            default: return "R11";
        endcase
    endfunction

    task automatic model_reset();
        m_cnt = 0; m_lat = 0; m_ctrl = 0; m_ien = 0;
        m_pend = 0; m_armed = 0; m_flag = 0; m_wave = 0;
    endtask

    // one clock: outputs compared, inputs driven, model advanced
    task automatic cyc(input bit w, input bit r, input int a, input int d,
                       input bit t, input bit p, input string tag);
        bit tmo, clr;
        @(negedge clk);
        check("R8", irq_n, !(m_flag && m_ien[6]));
        check("R9", wave_pin, m_ctrl[0] ? m_wave : port_in);
        bus_wr = w; bus_rd = r; bus_addr = a[2:0]; bus_wdata = d[7:0];
        tick = t; port_in = p;
        #1;
        if (r) check(tag == "" ? tag_of(a) : tag, bus_rdata, exp_read(a));
        @(posedge clk);
        tmo = 0;
        if (w && a == 1) begin
            m_cnt = (d << 8) | (m_lat & 8'hFF);
            m_pend = 0; m_armed = 1; m_flag = 0;
        end else if (t && m_armed) begin
            if (m_pend) begin m_cnt = m_lat; m_pend = 0; end
            else if (m_cnt == 0) begin m_pend = 1; tmo = 1; end
            else m_cnt = m_cnt - 1;
        end
        clr = (r && a == 0) || (w && a == 3) || (w && a == 5 && d[6]);
        if (tmo) begin m_flag = 1; m_wave = !m_wave; toggles++; end
        else if (clr) m_flag = 0;
        if (w && (a == 0 || a == 2)) m_lat = (m_lat & 16'hFF00) | d;
        if (w && (a == 1 || a == 3)) m_lat = (m_lat & 16'h00FF) | (d << 8);
        if (w && a == 4) m_ctrl = d;
        if (w && a == 6) m_ien = d;
    endtask

    task automatic wr(input int a, input int d, input bit t);
        cyc(1, 0, a, d, t, port_in, "");
    endtask

    task automatic rd(input int a, input bit t, input string tag);
        cyc(0, 1, a, 0, t, port_in, tag);
    endtask

    task automatic idle(input int n, input int div);
        for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, (i % div) == 0, port_in, "");
    endtask

    initial begin
        #4_000_000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        model_reset();
        toggles = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1: reset state, and an unarmed counter ignores ticks
        check("R1", irq_n, 1);
        check("R1", wave_pin, 0);
        for (int a = 0; a < 8; a++) rd(a, 1, "R1");
        idle(5, 1);
        rd(0, 0, "R1");
        check("R1", toggles, 0);

        // R11: control and enable read back
        wr(4, 8'h01, 0);
        wr(6, 8'h40, 0);
        rd(4, 0, "R11"); rd(6, 0, "R11"); rd(7, 0, "R11");

        // R5 / R3: latch 5, retrigger, spacing latch+2 with tick every cycle
        wr(2, 5, 1);
        wr(1, 0, 1);
        rd(0, 0, "R5"); rd(1, 0, "R5"); rd(3, 0, "R5");
        toggles = 0;
        idle(6, 1);
        check("R3", toggles, 1);
        rd(5, 0, "R7");
        idle(7, 1);
        check("R3", toggles, 2);

        // R6: clear by low counter read, by flag write, by high latch write
        rd(0, 0, "R6"); rd(5, 0, "R6");
        idle(7, 1);
        wr(5, 8'hBF, 0); rd(5, 0, "R7");
        wr(5, 8'h40, 0); rd(5, 0, "R6");
        idle(7, 1);
        rd(1, 0, "R10"); rd(5, 0, "R10");
        wr(3, 0, 0); rd(5, 0, "R6");

        // R4: latch changes mid-count only affect the next period
        wr(2, 3, 1);
        rd(0, 0, "R4");
        idle(20, 1);
        wr(0, 9, 1);
        wr(3, 1, 1);
        rd(0, 1, "R4"); rd(1, 1, "R4");
        wr(3, 0, 0);

        // R6: clear coinciding with timeout loses
        for (int i = 0; i < 30; i++) begin
            if (i % 4 == 0) cyc(0, 1, 0, 0, 1, port_in, "R6");
            else cyc(0, 0, 0, 0, 1, port_in, "");
        end

        // R5: repeated retrigger prevents timeout, even alongside ticks
        wr(5, 8'h40, 0);
        wr(2, 4, 0);
        toggles = 0;
        for (int k = 0; k < 10; k++) begin
            wr(1, 0, 1);
            idle(3, 1);
        end
        check("R5", toggles, 0);
        rd(5, 0, "R5");

        // R2: slow tick, every third cycle
        wr(1, 0, 0);
        idle(40, 3);
        rd(0, 0, "R2"); rd(1, 0, "R2");

        // R9: wave off, pin follows port data
        wr(4, 0, 0);
        for (int i = 0; i < 6; i++) cyc(0, 0, 0, 0, 1, i[0], "");
        wr(4, 1, 0);

        // R8: enable masked
        wr(6, 0, 0);
        idle(10, 1);
        rd(5, 0, "R8");
        wr(6, 8'h40, 0);
        idle(3, 1);
        rd(5, 0, "R8");

        idle(5, 1);
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule